// File: doc/BRIEF.md
# Two-Wire Bus Target with Strap-Selected Address

This block is the target side of a two-wire serial bus (I2C). It samples the clock and data lines through synchronizers and detects START and STOP conditions. After a START it collects the seven address bits and the direction bit. It answers with an acknowledge only when the address equals its own identity.

That identity is a fixed upper part, set by a parameter, with its low two or three bits taken from strap pins. Several copies of the same target can therefore sit on one bus. After an accepted address, the block either takes bytes from the controller or sends bytes to it. A single-byte local port carries the data. Between bytes, the block holds the clock line low for as long as the local side reports that it is not ready.

The block never drives a line high. It only asserts drive-low enables, and the pull-ups outside the block restore the high level.

Top module: `i2c_pin_target`

## Requirements
- R1: After a START, the target shifts in 7 address bits (MSB first) and then a direction bit (1 = read, 0 = write), each sampled on a rising SCL. On an address match, it asserts `sda_drive_low` from the falling edge of the 8th pulse through the falling edge of the 9th.
- R2: On an address mismatch, the target leaves SDA released for the acknowledge pulse and the rest of the transfer. It then ignores the bus until the next START.
- R3: `PIN_BITS` may be only 2 or 3. The own address is `{BASE_ADDR[6:PIN_BITS], addr_pins}`, so with the defaults (`BASE_ADDR`=0x50, `PIN_BITS`=3) pins 5 give address 0x55.
- R4: In write mode, each 8-bit data byte (MSB first) is acknowledged on the 9th pulse. The byte appears on `rx_byte`, with `rx_valid` high for exactly one clock.
- R5: In read mode, the target samples `tx_byte` and pulses `tx_load` for one clock when it starts a byte. It drives the bits MSB first, releasing SDA for a 1 and pulling it low for a 0, and it releases SDA for the 9th pulse.
- R6: In read mode, a NACK from the controller (SDA high on the 9th pulse) ends the transfer. SDA stays released until the next START.
- R7: After the falling edge of each 9th pulse, the target holds SCL low while `loc_ready` is low. It releases SCL one clock after it has placed the next bit, once `loc_ready` is high.
- R8: A STOP (SDA rising while SCL is high) releases both lines and returns the target to idle from any state. After reset, both drive-low enables are 0.
- R9: A START seen in the middle of a transfer (a repeated START) restarts address reception.
- R10: START and STOP are recognized only as SDA edges while SCL is high, seen through two-flop synchronizers. SDA activity while SCL is low starts nothing.
- R11: `sda_drive_low` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| scl_drive_low | output | 1 | 1 pulls SCL low (stretching) |
| sda_drive_low | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| addr_pins | input | PIN_BITS | Strap pins forming the low address bits |
| loc_ready | input | 1 | Local side is ready for the next byte |
| tx_byte | input | 8 | Byte to send in read mode |
| tx_load | output | 1 | One-clock pulse when `tx_byte` is taken |
| rx_byte | output | 8 | Last byte received in write mode |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` is new |

## Verification
The bench targets strap values that differ from the address in only the low bits, or only the upper bits. A comparator that ignores the pins, or compares the wrong slice, would acknowledge foreign addresses or miss its own. It holds `loc_ready` low after an acknowledge; a target that fails to stretch would let the next byte pass unseen. It also ends a read with a NACK and checks that SDA stays released; a target that keeps sending would corrupt the STOP. Two further cases probe condition detection. A repeated START must lead to a fresh address phase, and a frame clocked without any START must draw no acknowledge. A target that treated plain SDA edges as START would answer that frame.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 7;
   localparam int CNT_W   = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_GAP,
      ST_DATA,
      ST_DACK
   } tgt_state_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("i2ct_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2ct_busmon.sv
module i2ct_busmon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/i2ct_addr_match.sv
module i2ct_addr_match #(
   parameter int         PIN_BITS  = 3,
   parameter logic [6:0] BASE_ADDR = 7'h50
) (
   input  logic [6:0]          rx_addr,
   input  logic [PIN_BITS-1:0] pins,
   output logic                hit
);
   logic [6:0] own;

   generate
      if (PIN_BITS == 2) begin : g_two
         assign own = {BASE_ADDR[6:2], pins};
      end else if (PIN_BITS == 3) begin : g_three
         assign own = {BASE_ADDR[6:3], pins};
      end else begin : g_bad
         $error("i2ct_addr_match: PIN_BITS must be 2 or 3");
         assign own = BASE_ADDR;
      end
   endgenerate

   assign hit = (rx_addr == own);
endmodule

// File: rtl/i2c_pin_target.sv
module i2c_pin_target
   import i2ct_pkg::*;
#(
   parameter int         PIN_BITS    = 3,
   parameter logic [6:0] BASE_ADDR   = 7'h50,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                scl_drive_low,
   output logic                sda_drive_low,
   input  logic [PIN_BITS-1:0] addr_pins,
   input  logic                loc_ready,
   input  logic [BYTE_W-1:0]   tx_byte,
   output logic                tx_load,
   output logic [BYTE_W-1:0]   rx_byte,
   output logic                rx_valid
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_pin_target: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, bus_start, bus_stop;
   logic addr_hit;

   i2ct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2ct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2ct_busmon u_mon (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(bus_start), .stop_det(bus_stop));

   tgt_state_e            state;
   logic [CNT_W-1:0]      bit_cnt;
   logic [BYTE_W-1:0]     shreg;
   logic                  dir_rd;
   logic                  ctl_nack;

   i2ct_addr_match #(.PIN_BITS(PIN_BITS), .BASE_ADDR(BASE_ADDR)) u_match (
      .rx_addr(shreg[7:1]), .pins(addr_pins), .hit(addr_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         bit_cnt       <= '0;
         shreg         <= '0;
         dir_rd        <= 1'b0;
         ctl_nack      <= 1'b0;
         sda_drive_low <= 1'b0;
         scl_drive_low <= 1'b0;
         rx_byte       <= '0;
         rx_valid      <= 1'b0;
         tx_load       <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_load  <= 1'b0;
         if (bus_stop) begin
            state         <= ST_IDLE;
            sda_drive_low <= 1'b0;
            scl_drive_low <= 1'b0;
         end else if (bus_start) begin
            state         <= ST_ADDR;
            bit_cnt       <= '0;
            sda_drive_low <= 1'b0;
            scl_drive_low <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == LAST_BIT) begin
                     if (addr_hit) begin
                        sda_drive_low <= 1'b1;
                        dir_rd        <= shreg[0];
                        state         <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     sda_drive_low <= 1'b0;
                     scl_drive_low <= ~loc_ready;
                     state         <= ST_GAP;
                  end
               end
               ST_GAP: begin
                  if (loc_ready) begin
                     bit_cnt <= '0;
                     state   <= ST_DATA;
                     if (dir_rd) begin
                        shreg         <= tx_byte;
                        tx_load       <= 1'b1;
                        sda_drive_low <= ~tx_byte[BYTE_W-1];
                     end
                  end else begin
                     scl_drive_low <= 1'b1;
                  end
               end
               ST_DATA: begin
                  scl_drive_low <= 1'b0;
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                     if (!dir_rd) shreg <= {shreg[BYTE_W-2:0], sda_s};
                  end else if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        state <= ST_DACK;
                        if (!dir_rd) begin
                           rx_byte       <= shreg;
                           rx_valid      <= 1'b1;
                           sda_drive_low <= 1'b1;
                        end else begin
                           sda_drive_low <= 1'b0;
                        end
                     end else if (dir_rd) begin
                        shreg         <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_drive_low <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_DACK: begin
                  if (scl_rise) begin
                     ctl_nack <= sda_s;
                  end else if (scl_fall) begin
                     sda_drive_low <= 1'b0;
                     if (dir_rd && ctl_nack) begin
                        state <= ST_IDLE;
                     end else begin
                        scl_drive_low <= ~loc_ready;
                        state         <= ST_GAP;
                     end
                  end
               end
               default: begin
                  state         <= ST_IDLE;
                  sda_drive_low <= 1'b0;
                  scl_drive_low <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_pin_target_chk.sv
module i2c_pin_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic bus_start,
   input logic bus_stop,
   input logic loc_ready,
   input logic scl_drive_low,
   input logic sda_drive_low,
   input logic rx_valid,
   input logic tx_load
);
   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> (!sda_drive_low && !scl_drive_low));

   p_restart_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !scl_drive_low);

   p_stretch_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> $past(!loc_ready));

   p_sda_when_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_s));

   p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);
endmodule

bind i2c_pin_target i2c_pin_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
   .bus_start(bus_start), .bus_stop(bus_stop), .loc_ready(loc_ready),
   .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
   .rx_valid(rx_valid), .tx_load(tx_load));

// File: tb/i2c_pin_target_tb_top.sv
module i2c_pin_target_tb_top;
   localparam int Q = 20;
   localparam int NVEC = 8;
   // {pins[2:0], addr[6:0], expect_ack}
   localparam logic [10:0] VEC [NVEC] = '{
      {3'd0, 7'h50, 1'b1}, {3'd5, 7'h55, 1'b1}, {3'd5, 7'h50, 1'b0},
      {3'd7, 7'h57, 1'b1}, {3'd3, 7'h57, 1'b0}, {3'd2, 7'h52, 1'b1},
      {3'd2, 7'h12, 1'b0}, {3'd6, 7'h56, 1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_c = 1'b1, sda_c = 1'b1;
   logic [2:0] pins = 3'd1;
   logic loc_ready = 1'b1;
   logic [7:0] tx_byte = 8'h00;
   logic scl_drive_low, sda_drive_low, tx_load, rx_valid;
   logic [7:0] rx_byte;
   logic scl_bus, sda_bus;
   int total = 0, bad = 0;
   int rx_cnt = 0, tx_cnt = 0;
   logic [7:0] rx_last = 8'h00;
   logic finished = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_bus = scl_c & ~scl_drive_low;
   assign sda_bus = sda_c & ~sda_drive_low;

   i2c_pin_target dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .addr_pins(pins), .loc_ready(loc_ready), .tx_byte(tx_byte),
      .tx_load(tx_load), .rx_byte(rx_byte), .rx_valid(rx_valid));

   always @(posedge clk) begin
      if (rx_valid) begin
         rx_cnt  <= rx_cnt + 1;
         rx_last <= rx_byte;
      end
      if (tx_load) tx_cnt <= tx_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic pulse(output logic s);
      waitq();
      scl_c = 1'b1;
      while (!scl_bus) @(negedge clk);
      waitq();
      s = sda_bus;
      scl_c = 1'b0;
      waitq();
   endtask

   task automatic send_bit(input logic b);
      logic d;
      sda_c = b;
      pulse(d);
   endtask

   task automatic bus_start();
      sda_c = 1'b1;
      waitq();
      scl_c = 1'b1;
      while (!scl_bus) @(negedge clk);
      waitq();
      sda_c = 1'b0;
      waitq();
      scl_c = 1'b0;
      waitq();
   endtask

   task automatic bus_stop();
      sda_c = 1'b0;
      waitq();
      scl_c = 1'b1;
      while (!scl_bus) @(negedge clk);
      waitq();
      sda_c = 1'b1;
      waitq();
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_c = 1'b1;
      pulse(s);
      ack = ~s;
   endtask

   task automatic get_byte(input logic nack, output logic [7:0] d);
      logic s;
      sda_c = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         pulse(s);
         d[i] = s;
      end
      send_bit(nack);
   endtask

   initial begin
      logic ack;
      logic [7:0] d;
      int rx0, tx0;
      repeat (10) @(negedge clk);
      chk("R8 reset sda", sda_drive_low, 0);
      chk("R8 reset scl", scl_drive_low, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R1 R2 R3: address vector table
      for (int v = 0; v < NVEC; v++) begin
         pins = VEC[v][10:8];
         bus_start();
         put_byte({VEC[v][7:1], 1'b0}, ack);
         chk(VEC[v][0] ? "R1 R3 ack on match" : "R2 R3 no ack on mismatch", ack, VEC[v][0]);
         bus_stop();
      end

      // R4: write two bytes
      pins = 3'd1;
      rx0 = rx_cnt;
      bus_start();
      put_byte({7'h51, 1'b0}, ack);
      chk("R1 write addr ack", ack, 1);
      put_byte(8'hA5, ack);
      chk("R4 ack byte0", ack, 1);
      chk("R4 data byte0", rx_last, 8'hA5);
      put_byte(8'h3C, ack);
      chk("R4 ack byte1", ack, 1);
      chk("R4 data byte1", rx_last, 8'h3C);
      chk("R4 rx count", rx_cnt - rx0, 2);
      bus_stop();
      repeat (5) @(negedge clk);
      chk("R8 stop releases sda", sda_drive_low, 0);
      chk("R8 stop releases scl", scl_drive_low, 0);

      // R7: stretch while local side not ready
      loc_ready = 1'b0;
      bus_start();
      put_byte({7'h51, 1'b0}, ack);
      chk("R7 addr ack", ack, 1);
      repeat (100) @(negedge clk);
      chk("R7 scl held low", scl_drive_low, 1);
      chk("R7 bus scl low", scl_bus, 0);
      loc_ready = 1'b1;
      repeat (10) @(negedge clk);
      chk("R7 scl released", scl_drive_low, 0);
      put_byte(8'h81, ack);
      chk("R7 byte after stretch", rx_last, 8'h81);
      bus_stop();

      // R5 R6: read two bytes, NACK the last
      tx0 = tx_cnt;
      tx_byte = 8'hC6;
      bus_start();
      put_byte({7'h51, 1'b1}, ack);
      chk("R1 read addr ack", ack, 1);
      tx_byte = 8'h3B;
      get_byte(1'b0, d);
      chk("R5 read byte0", d, 8'hC6);
      get_byte(1'b1, d);
      chk("R5 read byte1", d, 8'h3B);
      chk("R5 load count", tx_cnt - tx0, 2);
      repeat (10) @(negedge clk);
      chk("R6 sda released after nack", sda_drive_low, 0);
      sda_c = 1'b1;
      pulse(ack);
      chk("R6 no drive after nack", ack, 1);
      bus_stop();

      // R9: repeated START restarts address phase
      rx0 = rx_cnt;
      bus_start();
      put_byte({7'h51, 1'b0}, ack);
      put_byte(8'h11, ack);
      bus_start();
      put_byte({7'h51, 1'b0}, ack);
      chk("R9 ack after restart", ack, 1);
      put_byte(8'h22, ack);
      chk("R9 data after restart", rx_last, 8'h22);
      chk("R9 rx count", rx_cnt - rx0, 2);
      bus_stop();

      // R10: frame without START draws no ack
      waitq();
      scl_c = 1'b0;
      waitq();
      sda_c = 1'b0;
      waitq();
      sda_c = 1'b1;
      waitq();
      put_byte({7'h51, 1'b0}, ack);
      chk("R10 no ack without start", ack, 0);
      sda_c = 1'b1;
      waitq();
      scl_c = 1'b1;
      waitq();

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule